// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 9-bit first-in first-out buffer whose write side and read side each run on their own clock, with no phase or frequency relation between the two. Words are pushed on the write clock and popped into an output register on the read clock. Four status outputs report the fill state. The write domain produces full and almost-full, and the read domain produces empty and almost-empty. The data output can be released to high impedance.

The almost-empty and almost-full thresholds are held in two offset registers. Software reaches them through the normal data pins. A strap level sampled while reset is active decides the role of the shared pin `wen2_ld`. Held high during reset, it becomes a second write enable. Held low during reset, it becomes a load control, and then offset accesses step through the four register halves in a fixed rotation. The depth is a parameter, so a small instance can be used in simulation.

Top module: `dcfifo_pflags`

## Requirements
- R1: While and after reset, with no transfers, `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0.
- R2: Words leave in the order they were written. A word popped on a read-clock rising edge is on `q` after that edge, and the first pop after `empty` falls returns the oldest word.
- R3: A push happens on a `wclk` rising edge only when the write enables are satisfied and `full`=0. `full`=1 exactly when DEPTH words are stored, and pushes while full are discarded.
- R4: A pop happens only when `ren1`=1, `ren2`=1, the load control is not active and `empty`=0. Otherwise `q` keeps its previous value.
- R5: `oe_n`=0 drives `q` from the output register. `oe_n`=1 puts `q` in high impedance.
- R6: If `wen2_ld`=1 while `rst_n`=0, it then acts as a second active-high write enable. If it is 0, it then acts as a load control: when high, accesses go to the offset registers; when low, `wen1` alone pushes data.
- R7: In load mode, each `wen1` write with `wen2_ld`=1 targets the next position of the rotation. The order is empty-offset low 9 bits, empty-offset upper bits, full-offset low 9 bits, full-offset upper bits, and then it wraps. Readback with `ren1`=`ren2`=1 and `wen2_ld`=1 loads `q` from the same rotation. Both rotations restart at the first position on reset.
- R8: Both offset registers hold 7 after reset.
- R9: `almost_full`=1 exactly when the number of free locations is at most the full offset.
- R10: `almost_empty`=1 exactly when the number of stored words is at most the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wen1 | input | 1 | Write enable |
| wen2_ld | input | 1 | Second write enable, or offset load control (strap chooses) |
| d | input | 9 | Write data / offset data |
| ren1 | input | 1 | Read enable 1 |
| ren2 | input | 1 | Read enable 2 |
| oe_n | input | 1 | Output enable, active low |
| q | output | 9 | Read data, tri-state |
| full | output | 1 | Full flag (write domain) |
| almost_full | output | 1 | Almost-full flag (write domain) |
| empty | output | 1 | Empty flag (read domain) |
| almost_empty | output | 1 | Almost-empty flag (read domain) |

## Verification
Some results are due right after the clock edge that caused them: a pop or readback shows on `q`, and a flag in the domain that made the change updates at once. The bench therefore compares these at the falling edge that follows the active edge. A change made in the other domain reaches a flag only after one Gray register and two synchronizer edges of the destination clock. So after each burst the bench waits four edges of both clocks before it compares the cross-domain flags against its reference count. Within a burst only one side moves, which keeps the reference exact for every accept decision.

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int W  = 9,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wen1,
  input  logic         wen2_ld,
  input  logic [W-1:0] d,
  input  logic         ren1,
  input  logic         ren2,
  input  logic         oe_n,
  output wire  [W-1:0] q,
  output logic         full,
  output logic         almost_full,
  output logic         empty,
  output logic         almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int MW    = (PW > W) ? PW - W : 1;
  localparam int OW    = W + MW;
  localparam logic [OW-1:0] OFS_INIT = OW'(7);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic          ld_mode;
  logic [PW-1:0] wptr, wgray, rs1, rs2, wcount, wfree;
  logic [PW-1:0] rptr, rgray, ws1, ws2, rcount;
  logic [OW-1:0] eofs, fofs;
  logic [1:0]    wsel, rsel;
  logic [W-1:0]  q_reg;

  // strap: sampled on wclk while reset is held
  always_ff @(posedge wclk)
    if (!rst_n) ld_mode <= ~wen2_ld;

  wire ld_act = ld_mode & wen2_ld;
  wire wen_ok = wen1 & (ld_mode ? ~wen2_ld : wen2_ld);
  wire wr_go  = wen_ok & ~full;
  wire ofs_wr = wen1 & ld_act;
  wire [PW-1:0] wnext = wptr + PW'(wr_go);

  always_ff @(posedge wclk)
    if (wr_go) mem[wptr[AW-1:0]] <= d;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rs1   <= '0;
      rs2   <= '0;
      eofs  <= OFS_INIT;
      fofs  <= OFS_INIT;
      wsel  <= 2'd0;
    end else begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
      rs1   <= rgray;
      rs2   <= rs1;
      if (ofs_wr) begin
        wsel <= wsel + 2'd1;
        case (wsel)
          2'd0: eofs[W-1:0]  <= d;
          2'd1: eofs[OW-1:W] <= d[MW-1:0];
          2'd2: fofs[W-1:0]  <= d;
          default: fofs[OW-1:W] <= d[MW-1:0];
        endcase
      end
    end
  end

  assign wcount      = wptr - g2b(rs2);
  assign wfree       = PW'(DEPTH) - wcount;
  assign full        = (wcount == PW'(DEPTH));
  assign almost_full = (OW'(wfree) <= fofs);

  wire rd_en = ren1 & ren2;
  wire rd_go = rd_en & ~ld_act & ~empty;
  wire rb_go = rd_en & ld_act;
  wire [PW-1:0] rnext = rptr + PW'(rd_go);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      ws1   <= '0;
      ws2   <= '0;
      rsel  <= 2'd0;
      q_reg <= '0;
    end else begin
      rptr  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
      ws1   <= wgray;
      ws2   <= ws1;
      if (rd_go) q_reg <= mem[rptr[AW-1:0]];
      else if (rb_go) begin
        rsel <= rsel + 2'd1;
        case (rsel)
          2'd0: q_reg <= eofs[W-1:0];
          2'd1: q_reg <= W'(eofs[OW-1:W]);
          2'd2: q_reg <= fofs[W-1:0];
          default: q_reg <= W'(fofs[OW-1:W]);
        endcase
      end
    end
  end

  assign rcount       = g2b(ws2) - rptr;
  assign empty        = (rcount == '0);
  assign almost_empty = (OW'(rcount) <= eofs);
  assign q            = oe_n ? {W{1'bz}} : q_reg;

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> (wptr == $past(wptr)));
  p_level_bound_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= PW'(DEPTH));
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> (rptr == $past(rptr)));
  p_q_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_go || rb_go) |=> $stable(q_reg));
  p_sel_step_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    ofs_wr |=> (wsel == $past(wsel) + 2'd1));
  p_af_with_full_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  p_ae_with_empty_r10: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

// File: tb/dcfifo_pflags_tb.sv
module dcfifo_pflags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_HALF  = 7;
  localparam int W = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1 = 0, wen2_ld = 1, ren1 = 0, ren2 = 0, oe_n = 0;
  logic [W-1:0] d = '0;
  wire  [W-1:0] q;
  logic full, almost_full, empty, almost_empty;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_HALF) rclk = ~rclk;

  dcfifo_pflags #(.W(W), .AW(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1(wen1), .wen2_ld(wen2_ld),
    .d(d), .ren1(ren1), .ren2(ren2), .oe_n(oe_n), .q(q), .full(full),
    .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int model[$];
  int eofs_m = 7, fofs_m = 7;
  bit ldm = 0;
  logic [W-1:0] last_q = '0;

  function automatic bit exp_af(int c, int f); return (DEPTH - c) <= f; endfunction
  function automatic bit exp_ae(int c, int e); return c <= e; endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_q(string tag, logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q got %h expected %h", tag, q, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic chk_flags(string tag);
    int c = model.size();
    chk({tag, " R3 full"}, full, c == DEPTH);
    chk({tag, " R9 almost_full"}, almost_full, exp_af(c, fofs_m));
    chk({tag, " empty"}, empty, c == 0);
    chk({tag, " R10 almost_empty"}, almost_empty, exp_ae(c, eofs_m));
  endtask

  task automatic do_reset(bit strap);
    @(negedge wclk);
    rst_n = 0; wen1 = 0; ren1 = 0; ren2 = 0; wen2_ld = strap;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    model.delete();
    eofs_m = 7; fofs_m = 7; ldm = !strap; last_q = '0;
    if (ldm) wen2_ld = 0;
  endtask

  task automatic write_burst(int n, bit pin);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] v = W'($urandom);
      bit acc;
      @(negedge wclk);
      wen1 = 1; wen2_ld = pin; d = v;
      @(posedge wclk);
      acc = (ldm ? !pin : pin) && (model.size() < DEPTH);
      if (acc) model.push_back(int'(v));
      @(negedge wclk);
      wen1 = 0; wen2_ld = ldm ? 1'b0 : 1'b1;
      chk("R3 full during write", full, model.size() == DEPTH);
      chk("R9 af during write", almost_full, exp_af(model.size(), fofs_m));
    end
  endtask

  task automatic read_burst(int n, bit en2);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] e = last_q;
      @(negedge rclk);
      ren1 = 1; ren2 = en2;
      @(posedge rclk);
      if (en2 && model.size() > 0) e = W'(model.pop_front());
      @(negedge rclk);
      ren1 = 0; ren2 = 0;
      if (e == last_q) chk_q("R4 q hold or R2 data", e);
      else chk_q("R2 data order", e);
      last_q = e;
      chk("R10 ae during read", almost_empty, exp_ae(model.size(), eofs_m));
    end
  endtask

  task automatic wr_ofs(logic [W-1:0] v);
    @(negedge wclk);
    wen1 = 1; wen2_ld = 1; d = v;
    @(negedge wclk);
    wen1 = 0; wen2_ld = 0;
  endtask

  task automatic rd_ofs(logic [W-1:0] e, string tag);
    @(negedge wclk);
    wen2_ld = 1;
    @(negedge rclk);
    ren1 = 1; ren2 = 1;
    @(negedge rclk);
    ren1 = 0; ren2 = 0;
    chk_q(tag, e);
    last_q = e;
    @(negedge wclk);
    wen2_ld = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge wclk);
    // R1 reset state while reset held
    chk("R1 full in reset", full, 0);
    chk("R1 af in reset", almost_full, 0);
    chk("R1 empty in reset", empty, 1);
    chk("R1 ae in reset", almost_empty, 1);
    do_reset(1'b1);
    settle();
    chk_flags("R1 after reset");
    // R8: default offsets of 7
    write_burst(7, 1); settle(); chk_flags("R8 count7");
    chk("R8 ae at 7", almost_empty, 1);
    write_burst(1, 1); settle(); chk("R8 ae at 8", almost_empty, 0);
    chk("R8 af at 8", almost_full, 0);
    write_burst(1, 1); settle(); chk("R8 af at 9", almost_full, 1);
    // R3: fill beyond depth
    write_burst(DEPTH, 1); settle(); chk_flags("R3 overfill");
    chk("R3 level capped", model.size(), DEPTH);
    // R2/R4: drain plus extra reads on empty
    read_burst(DEPTH + 2, 1); settle(); chk_flags("R4 drained");
    // R6: second enable low blocks writes
    write_burst(3, 0); settle(); chk("R6 wen2 low no push", empty, 1);
    write_burst(4, 1); settle();
    read_burst(2, 0); settle(); chk_flags("R4 ren2 low no pop");
    // R5 tri-state
    @(negedge rclk); oe_n = 1; #1;
    n_chk++;
    if (q !== {W{1'bz}}) begin n_bad++; $display("FAIL R5: q got %h expected zzz", q); end
    oe_n = 0; #1; chk_q("R5 drive back", last_q);
    read_burst(4, 1); settle();
    // random mix
    for (int r = 0; r < 40; r++) begin
      int len = 1 + ($urandom % 20);
      bit en2 = ($urandom % 4) != 0;
      if ($urandom % 2) write_burst(len, en2); else read_burst(len, en2);
      settle();
      chk_flags("random");
    end
    read_burst(DEPTH + 1, 1); settle();
    // R6/R7 load mode
    do_reset(1'b0);
    settle(); chk_flags("R6 load-mode reset");
    rd_ofs(9'd7, "R8 empty ofs lsb default");
    rd_ofs(9'd0, "R8 empty ofs msb default");
    rd_ofs(9'd7, "R8 full ofs lsb default");
    rd_ofs(9'd0, "R8 full ofs msb default");
    wr_ofs(9'd2); wr_ofs(9'd0); wr_ofs(9'd3); wr_ofs(9'd0);
    eofs_m = 2; fofs_m = 3;
    rd_ofs(9'd2, "R7 readback empty lsb");
    rd_ofs(9'd0, "R7 readback empty msb");
    rd_ofs(9'd3, "R7 readback full lsb");
    rd_ofs(9'd0, "R7 readback full msb");
    write_burst(2, 0); settle(); chk("R10 ae at 2", almost_empty, 1);
    write_burst(1, 0); settle(); chk("R10 ae at 3", almost_empty, 0);
    write_burst(9, 0); settle(); chk("R9 af at 12", almost_full, 0);
    write_burst(1, 0); settle(); chk("R9 af at 13", almost_full, 1);
    chk_flags("R6 load-mode fill");
    read_burst(DEPTH, 1); settle(); chk_flags("R6 load-mode drain");
    // R7 rotation restarts on reset
    wr_ofs(9'd5);
    do_reset(1'b0);
    wr_ofs(9'd4);
    eofs_m = 4;
    rd_ofs(9'd4, "R7 rotation restart");
    settle(); chk_flags("R7 after restart");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule